// File: doc/BRIEF.md
# Current-Source Bridge Gate Commutation Sequencer

This block drives the seven gates of a current-source bridge: six bridge switches and one shunt switch placed across the dc inductor. A controller requests one of ten bridge states on a sampling strobe. The states are six active states, three null states and one freewheeling state. The block decodes the state into a gate pattern. Because the inductor current must never be interrupted, the block never simply swaps one gate pattern for another.

When the requested pattern differs from the settled one, the block drives the union of the old and new patterns for a programmable number of clock cycles. It then drops the switches that belong only to the old pattern. Under this one rule the shunt gate rises before the bridge pair goes low when the bridge enters freewheeling. When the bridge leaves freewheeling, the incoming pair rises before the shunt gate falls. Switches shared by the old and new states stay on throughout. No gate ever falls on the same clock edge on which another gate rises, and there is no dead time.

A request sampled while a transition is in progress is held, and the newest one replaces any older held request. The held request is acted on once the transition completes. An out-of-range state code steers the bridge to a safe null state and raises a fault flag that only reset clears.

Top module: `csi_gate_sequencer`

## Requirements
- R1: After reset, gate_o is 7'b0010010 (switches 1 and 4 on, shunt off), busy_o is 0 and fault_o is 0.
- R2: gate_o bit i drives switch i and bit 0 drives the shunt switch. Null codes 6, 7 and 8 settle to switch pairs {1,4}, {3,6} and {5,2} respectively.
- R3: Active codes 0 to 5 settle to switch pairs {1,2}, {3,2}, {3,4}, {5,4}, {5,6} and {1,6} respectively.
- R4: Code 9 (freewheel) settles to the shunt switch alone, with all six bridge gates low.
- R5: A request is sampled at a clock edge where req_tick is high. If its pattern differs from the settled pattern, then from the next edge gate_o shows the union of the old and new patterns for exactly L cycles, and after that it shows the new pattern alone.
- R6: gate_o is never all zero, and no clock edge makes one gate rise while another gate falls.
- R7: L is ovl_len sampled at the edge where the union starts. An ovl_len of 0 is treated as 1.
- R8: A request whose pattern equals the settled pattern starts no transition: gate_o stays unchanged and busy_o stays low.
- R9: A request sampled while busy_o is high is held until the transition ends, and a later sampled request replaces it. Only the newest one is applied.
- R10: Codes 10 to 15 settle to the null pattern of R1 and set fault_o. fault_o stays high until reset.
- R11: busy_o is high exactly during the L union cycles, and gate_o does not change while busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_tick | input | 1 | Strobe that samples req_code |
| req_code | input | 4 | Requested bridge state code |
| ovl_len | input | OVL_W | Overlap length in cycles (0 is treated as 1) |
| gate_o | output | 7 | Gate drives: bit 0 shunt, bit i switch i |
| busy_o | output | 1 | Overlap interval in progress |
| fault_o | output | 1 | Sticky flag for an invalid state code |

## Verification
The bench builds the block with the default 8-bit overlap width. It drives overlap lengths of 0 to 6, which brings within reach the zero-to-one floor, single-cycle unions and requests that land in the middle of a union. Directed runs cover every entry into and exit from freewheeling, a request that repeats the settled state, and stacked requests during one overlap. Random requests then mix all ten valid codes at random strobe density. Invalid codes come last, so that the sticky fault flag is checked to persist through later valid traffic and to clear only on reset.

// File: rtl/csi_seq_pkg.sv
package csi_seq_pkg;
    localparam int NUM_GATES  = 7;
    localparam int CODE_W     = 4;
    localparam int LAST_VALID = 9;

    typedef logic [NUM_GATES-1:0] gate_vec_t;
    typedef logic [CODE_W-1:0]    code_t;

    localparam code_t     CODE_FREEWHEEL = code_t'(9);
    localparam gate_vec_t SAFE_PATTERN   = 7'b0010010;

    function automatic logic code_ok(input code_t c);
        return int'(c) <= LAST_VALID;
    endfunction
endpackage

// File: rtl/csi_state_decode.sv
module csi_state_decode
    import csi_seq_pkg::*;
(
    input  code_t     code_i,
    output gate_vec_t pattern_o
);
    always_comb begin
        unique case (code_i)
            4'd0:    pattern_o = 7'b0000110;
            4'd1:    pattern_o = 7'b0001100;
            4'd2:    pattern_o = 7'b0011000;
            4'd3:    pattern_o = 7'b0110000;
            4'd4:    pattern_o = 7'b1100000;
            4'd5:    pattern_o = 7'b1000010;
            4'd6:    pattern_o = 7'b0010010;
            4'd7:    pattern_o = 7'b1001000;
            4'd8:    pattern_o = 7'b0100100;
            4'd9:    pattern_o = 7'b0000001;
            default: pattern_o = SAFE_PATTERN;
        endcase
    end
endmodule

// File: rtl/csi_overlap_timer.sv
module csi_overlap_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             run_o,
    output logic             last_o
);
    typedef struct packed {
        logic             run;
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = (len_i == '0) ? LEN_W'(1) : len_i;
        end else if (t_q.run) begin
            if (t_q.cnt == LEN_W'(1)) t_d.run = 1'b0;
            else                      t_d.cnt = t_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign run_o  = t_q.run;
    assign last_o = t_q.run && (t_q.cnt == LEN_W'(1));

    assert_cnt_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.run |-> (t_q.cnt != '0));

    assert_run_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !t_q.run);
endmodule

// File: rtl/csi_gate_sequencer.sv
module csi_gate_sequencer
    import csi_seq_pkg::*;
#(
    parameter int OVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tick,
    input  logic [3:0]       req_code,
    input  logic [OVL_W-1:0] ovl_len,
    output logic [6:0]       gate_o,
    output logic             busy_o,
    output logic             fault_o
);
    typedef struct packed {
        code_t     req;
        gate_vec_t cur;
        gate_vec_t tgt;
        gate_vec_t gate;
        logic      err;
    } seq_t;

    seq_t      s_d, s_q;
    gate_vec_t want_pat;
    logic      tmr_start, tmr_run, tmr_last;

    csi_state_decode u_decode (
        .code_i    (s_q.req),
        .pattern_o (want_pat)
    );

    csi_overlap_timer #(.LEN_W(OVL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .len_i   (ovl_len),
        .run_o   (tmr_run),
        .last_o  (tmr_last)
    );

    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        if (!tmr_run) begin
            if (want_pat != s_q.cur) begin
                s_d.tgt   = want_pat;
                s_d.gate  = s_q.cur | want_pat;
                tmr_start = 1'b1;
            end
        end else if (tmr_last) begin
            s_d.gate = s_q.tgt;
            s_d.cur  = s_q.tgt;
        end
        if (req_tick) begin
            s_d.req = req_code;
            if (!code_ok(req_code)) s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.req  <= code_t'(6);
            s_q.cur  <= SAFE_PATTERN;
            s_q.tgt  <= SAFE_PATTERN;
            s_q.gate <= SAFE_PATTERN;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_o  = s_q.gate;
    assign busy_o  = tmr_run;
    assign fault_o = s_q.err;

    assert_never_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o != '0);

    assert_no_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(gate_o & ~$past(gate_o))) && (|(~gate_o & $past(gate_o)))));

    assert_settled_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ((($countones(gate_o) == 2) && !gate_o[0]) || (gate_o == 7'b0000001)));

    assert_hold_in_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(gate_o));

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);
endmodule

// File: tb/csi_gate_sequencer_tb.sv
module csi_gate_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_tick = 1'b0;
    logic [3:0] req_code = 4'd6;
    logic [7:0] ovl_len = 8'd1;
    logic [6:0] gate_o;
    logic       busy_o, fault_o;

    int n_chk = 0;
    int n_bad = 0;

    csi_gate_sequencer #(.OVL_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_tick(req_tick), .req_code(req_code),
        .ovl_len(ovl_len), .gate_o(gate_o), .busy_o(busy_o), .fault_o(fault_o)
    );

    always #4 clk = ~clk;

    function automatic logic [6:0] pair(input int up, input int lo);
        return 7'((1 << up) | (1 << lo));
    endfunction

    function automatic logic [6:0] expect_pat(input logic [3:0] c);
        case (c)
            4'd0: return pair(1, 2);
            4'd1: return pair(3, 2);
            4'd2: return pair(3, 4);
            4'd3: return pair(5, 4);
            4'd4: return pair(5, 6);
            4'd5: return pair(1, 6);
            4'd6: return pair(1, 4);
            4'd7: return pair(3, 6);
            4'd8: return pair(5, 2);
            4'd9: return 7'b0000001;
            default: return pair(1, 4);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, built from the timing in the requirements
    logic [3:0] m_req;
    logic [6:0] m_cur, m_tgt, m_gate;
    int         m_cnt;
    logic       m_busy, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = 4'd6; m_cur = pair(1, 4); m_tgt = m_cur; m_gate = m_cur;
            m_cnt = 0; m_busy = 1'b0; m_err = 1'b0;
        end else begin
            if (!m_busy) begin
                if (expect_pat(m_req) != m_cur) begin
                    m_tgt  = expect_pat(m_req);
                    m_gate = m_cur | m_tgt;
                    m_cnt  = (ovl_len == 0) ? 1 : int'(ovl_len);
                    m_busy = 1'b1;
                end
            end else if (m_cnt == 1) begin
                m_gate = m_tgt; m_cur = m_tgt; m_busy = 1'b0;
            end else begin
                m_cnt--;
            end
            if (req_tick) begin
                m_req = req_code;
                if (req_code > 4'd9) m_err = 1'b1;
            end
        end
    end

    logic [6:0] prev_gate = 7'b0010010;
    logic       mon_on = 1'b0;

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk("R5 gates vs model", 32'(gate_o), 32'(m_gate));
            chk("R11 busy vs model", 32'(busy_o), 32'(m_busy));
            chk("R10 fault vs model", 32'(fault_o), 32'(m_err));
            chk("R6 never open", 32'(gate_o != 0), 32'd1);
            chk("R6 no rise with fall",
                32'((|(gate_o & ~prev_gate)) && (|(~gate_o & prev_gate))), 32'd0);
        end
        prev_gate = gate_o;
    end

    task automatic request(input logic [3:0] c, input logic [7:0] l);
        @(negedge clk);
        req_code = c; ovl_len = l; req_tick = 1'b1;
        @(negedge clk);
        req_tick = 1'b0;
    endtask

    task automatic window(input int n, input logic [6:0] pat, output int n_pat, output int n_busy);
        n_pat = 0; n_busy = 0;
        for (int i = 0; i < n; i++) begin
            if (gate_o == pat) n_pat++;
            if (busy_o) n_busy++;
            @(negedge clk);
        end
    endtask

    task automatic settle_to(input logic [3:0] c, input logic [7:0] l, input string tag);
        request(c, l);
        repeat (int'(l) + 4) @(negedge clk);
        chk(tag, 32'(gate_o), 32'(expect_pat(c)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int np, nb;
        do_reset();
        chk("R1 reset gates", 32'(gate_o), 32'h12);
        chk("R1 reset busy", 32'(busy_o), 32'd0);
        chk("R1 reset fault", 32'(fault_o), 32'd0);
        mon_on = 1'b1;

        // null A -> freewheel, union lasts 3 cycles
        request(4'd9, 8'd3);
        window(8, pair(1, 4) | 7'b1, np, nb);
        chk("R5 union length into freewheel", 32'(np), 32'd3);
        chk("R11 busy length", 32'(nb), 32'd3);
        chk("R4 freewheel shunt only", 32'(gate_o), 32'h01);

        // freewheel -> active 0, union lasts 2 cycles
        request(4'd0, 8'd2);
        window(8, pair(1, 2) | 7'b1, np, nb);
        chk("R5 union length out of freewheel", 32'(np), 32'd2);

        // zero length treated as one
        request(4'd1, 8'd0);
        window(6, pair(1, 2) | pair(3, 2), np, nb);
        chk("R7 zero overlap gives one cycle", 32'(nb), 32'd1);

        // same state again: no transition
        request(4'd1, 8'd5);
        window(8, pair(3, 2), np, nb);
        chk("R8 no busy on same state", 32'(nb), 32'd0);
        chk("R8 gates unchanged", 32'(np), 32'd8);

        for (int c = 0; c < 9; c++)
            settle_to(4'(c), 8'(1 + c % 3), (c < 6) ? "R3 active pattern" : "R2 null pattern");

        // stacked requests during one overlap: newest wins
        request(4'd2, 8'd4);
        request(4'd4, 8'd4);
        request(4'd7, 8'd4);
        repeat (20) @(negedge clk);
        chk("R9 newest held request applied", 32'(gate_o), 32'(expect_pat(4'd7)));

        // random traffic over valid codes
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            req_tick = ($urandom_range(0, 5) == 0);
            req_code = 4'($urandom_range(0, 9));
            ovl_len  = 8'($urandom_range(0, 6));
        end
        req_tick = 1'b0;
        repeat (12) @(negedge clk);

        // invalid code
        settle_to(4'd13, 8'd2, "R10 invalid gives safe null");
        chk("R10 fault raised", 32'(fault_o), 32'd1);
        settle_to(4'd9, 8'd2, "R4 freewheel after fault");
        chk("R10 fault sticky", 32'(fault_o), 32'd1);
        mon_on = 1'b0;
        do_reset();
        chk("R1 fault cleared by reset", 32'(fault_o), 32'd0);
        chk("R1 gates after second reset", 32'(gate_o), 32'h12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule